// File: doc/BRIEF.md
# Pause-width coded command transmitter

This block sends one reader-to-tag command frame by switching a carrier-enable output. Every bit opens with a fixed carrier-off gap and then turns the carrier back on. The value of the bit is carried by the total length of the bit: a long bit is a 1 and a short bit is a 0. Before a bit is coded, its data bit is XOR-scrambled with a keystream bit taken from an external generator. The block pulses a step strobe once per bit so that the generator moves forward.

All timing is counted on a timebase enable, `tick_i`, which runs at one thirty-second of the master clock; 150 ticks are about 100 µs. Data bits leave least-significant first, for the requested count. After the last bit, one more gap marks the end of the frame. At that moment a free-running tick timestamp returns to zero, so a receiver can time the tag reply from the end of the frame. Between frames the carrier stays on. A separate input forces the carrier off so that the tag can be reset.

Top module: `pause_code_tx`

## Requirements
- R1: Out of reset, `carrier_o` is 1 (when `kill_i` is 0), and `busy_o`, `done_o`, `ks_step_o` and `stamp_o` are all 0. While idle, the carrier stays on.
- R2: Each bit starts with `carrier_o` low for exactly PAUSE_T (30) ticks, after which the carrier turns on.
- R3: The coded value of bit i is `data_i[i]` XOR `ks_bit_i`, with `ks_bit_i` sampled on the tick that ends that bit's gap. The bit lasts ONE_T (150) ticks in total for a coded 1 and ZERO_T (90) ticks for a coded 0, gap included.
- R4: `ks_step_o` pulses for one clock per bit, in the same clock in which the carrier returns on after that bit's gap.
- R5: Bits are sent least-significant first. The number of bits sent is min(`nbits_i`, 32). A count of 0 sends only the end-of-frame gap.
- R6: After the last bit, the carrier is off for PAUSE_T ticks and then returns on. In that same clock, `done_o` is high for exactly one cycle and `busy_o` falls.
- R7: `stamp_o` is 0 in the clock where `done_o` is high. After that it increases by one for each tick, and it holds its value when `tick_i` is low.
- R8: A `start_i` pulse that arrives while `busy_o` is 1 is ignored. The running frame keeps its latched data and count, and no second frame follows it.
- R9: `kill_i` forces `carrier_o` low at once. It has no effect on `busy_o` or on the sequencing.
- R10: Durations are counted in ticks only. With ticks every third clock, the bit lengths measured in ticks are the same as with ticks on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable, one clock per tick |
| start_i | input | 1 | Starts a frame when the block is idle |
| data_i | input | DATA_W | Frame data, bit 0 is sent first |
| nbits_i | input | CNT_W | Number of bits to send, clamped to DATA_W |
| ks_bit_i | input | 1 | Current keystream bit |
| kill_i | input | 1 | Forces the carrier off |
| carrier_o | output | 1 | Carrier enable |
| ks_step_o | output | 1 | One-clock keystream advance strobe |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-clock pulse at the end of a frame |
| stamp_o | output | STAMP_W | Tick count since the last frame end |

## Verification
A tick counter that is off by one would make a gap read as 29 or 31 ticks, and it would show in the first bit of the first frame. A coded-value register that is latched wrongly, or a keystream sampled in the wrong clock, would turn a 150-tick bit into a 90-tick bit (or the reverse) within one bit time. A wrong remaining-bit count would show as an extra or a missing bit, and the length of the frame would betray it only when `done_o` arrives. A timestamp that is not cleared would show as a nonzero `stamp_o` in the done clock.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_MARK,
    ST_TAIL
  } tx_st_e;
endpackage

// File: rtl/pw_bit_src.sv
module pw_bit_src #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= data_i;
      left_q <= (nbits_i > MaxCnt) ? MaxCnt : nbits_i;
    end else if (shift_i) begin
      sr_q   <= sr_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (left_q == CNT_W'(1));
endmodule

// File: rtl/pw_seq.sv
module pw_seq
  import pw_pkg::*;
#(
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90,
  parameter int TW      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic nz_i,
  input  logic last_i,
  input  logic bit_i,
  input  logic ks_bit_i,
  output logic load_o,
  output logic shift_o,
  output logic frame_end_o,
  output logic car_o,
  output logic ks_step_o,
  output logic busy_o,
  output logic done_o
);
  tx_st_e        st_q;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] len_q;
  logic          gap_end, mark_end;

  assign gap_end     = (tcnt_q == TW'(PAUSE_T - 1));
  assign mark_end    = (tcnt_q == len_q - 1'b1);
  assign load_o      = (st_q == ST_IDLE) && start_i;
  assign shift_o     = (st_q == ST_MARK) && tick_i && mark_end;
  assign frame_end_o = (st_q == ST_TAIL) && tick_i && gap_end;
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tcnt_q    <= '0;
      len_q     <= TW'(ZERO_T);
      car_o     <= 1'b1;
      ks_step_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      ks_step_o <= 1'b0;
      done_o    <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= nz_i ? ST_GAP : ST_TAIL;
          tcnt_q <= '0;
          car_o  <= 1'b0;
        end
        ST_GAP: if (tick_i) begin
          tcnt_q <= tcnt_q + 1'b1;
          if (gap_end) begin
            st_q      <= ST_MARK;
            car_o     <= 1'b1;
            ks_step_o <= 1'b1;
            len_q     <= (bit_i ^ ks_bit_i) ? TW'(ONE_T) : TW'(ZERO_T);
          end
        end
        ST_MARK: if (tick_i) begin
          if (mark_end) begin
            tcnt_q <= '0;
            car_o  <= 1'b0;
            st_q   <= last_i ? ST_TAIL : ST_GAP;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_TAIL: if (tick_i) begin
          if (gap_end) begin
            st_q   <= ST_IDLE;
            car_o  <= 1'b1;
            done_o <= 1'b1;
            tcnt_q <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_stamp.sv
module pw_stamp #(
  parameter int SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  output logic [SW-1:0] stamp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stamp_o <= '0;
    else if (clr_i)  stamp_o <= '0;
    else if (tick_i) stamp_o <= stamp_o + 1'b1;
  end
endmodule

// File: rtl/pause_code_tx.sv
module pause_code_tx #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = $clog2(DATA_W + 1),
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90,
  parameter int STAMP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               ks_bit_i,
  input  logic               kill_i,
  output logic               carrier_o,
  output logic               ks_step_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [STAMP_W-1:0] stamp_o
);
  localparam int TW = $clog2(ONE_T + 1);

  logic load, shift, frame_end, car, cur_bit, last_bit;

  pw_bit_src #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .data_i (data_i),
    .nbits_i(nbits_i),
    .bit_o  (cur_bit),
    .last_o (last_bit)
  );

  pw_seq #(.PAUSE_T(PAUSE_T), .ONE_T(ONE_T), .ZERO_T(ZERO_T), .TW(TW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (start_i),
    .nz_i       (nbits_i != '0),
    .last_i     (last_bit),
    .bit_i      (cur_bit),
    .ks_bit_i   (ks_bit_i),
    .load_o     (load),
    .shift_o    (shift),
    .frame_end_o(frame_end),
    .car_o      (car),
    .ks_step_o  (ks_step_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  pw_stamp #(.SW(STAMP_W)) u_stamp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (frame_end),
    .stamp_o(stamp_o)
  );

  assign carrier_o = car & ~kill_i;
endmodule

// File: rtl/pw_tx_chk.sv
module pw_tx_chk #(
  parameter int STAMP_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               kill_i,
  input logic               carrier_o,
  input logic               ks_step_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [STAMP_W-1:0] stamp_o
);
  // R1
  idle_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !kill_i) |-> carrier_o);
  // R4
  step_on_carrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_step_o |-> (busy_o && (carrier_o || kill_i)));
  // R4
  step_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_step_o |=> !ks_step_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && (carrier_o || kill_i)));
  // R6
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R7
  stamp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stamp_o == '0));
  // R7
  stamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(stamp_o));
  // R9
  kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> !carrier_o);
  // R2
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !carrier_o);
endmodule

bind pause_code_tx pw_tx_chk #(.STAMP_W(STAMP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .kill_i   (kill_i),
  .carrier_o(carrier_o),
  .ks_step_o(ks_step_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .stamp_o  (stamp_o)
);

// File: tb/sim_pause_code_tx.sv
module sim_pause_code_tx;
  localparam int PT = 30, T1 = 150, T0 = 90;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [5:0]  nbits_i = '0;
  logic        ks_bit_i;
  logic        kill_i = 1'b0;
  logic        carrier_o, ks_step_o, busy_o, done_o;
  logic [15:0] stamp_o;

  int ntot = 0, nbad = 0;
  int tick_div = 1, tick_ph = 0;
  bit tick_en = 1'b0;

  logic [7:0] lfsr = 8'h5B;
  int  nb, lo_c, hi_c, steps, tail_lo, exp_stamp;
  int  bit_lo[64], bit_len[64];
  bit  prev_car, prev_busy, car_at_done, busy_at_done;
  int  stamp_at_done;

  assign ks_bit_i = lfsr[0];

  always #4 clk = ~clk;

  pause_code_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .data_i(data_i), .nbits_i(nbits_i), .ks_bit_i(ks_bit_i), .kill_i(kill_i),
    .carrier_o(carrier_o), .ks_step_o(ks_step_o), .busy_o(busy_o),
    .done_o(done_o), .stamp_o(stamp_o)
  );

  function automatic logic [7:0] lf_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic bit ks_at(input logic [7:0] seed, input int i);
    logic [7:0] s = seed;
    for (int k = 0; k < i; k++) s = lf_next(s);
    return s[0];
  endfunction

  // monitor, tick generator and keystream model in one process
  always @(negedge clk) begin
    if (done_o) exp_stamp = 0;
    else if (tick_i) exp_stamp++;
    if (ks_step_o) begin
      lfsr <= lf_next(lfsr);
      steps++;
    end
    if (busy_o && !prev_busy) begin
      nb = 0; lo_c = 0; hi_c = 0; steps = ks_step_o ? 1 : 0;
    end
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick_i  = tick_en && (tick_ph == 0);
    if (busy_o) begin
      if (!carrier_o) begin
        if (prev_car && hi_c > 0) begin
          if (nb < 64) begin
            bit_lo[nb]  = lo_c;
            bit_len[nb] = lo_c + hi_c;
          end
          nb++; lo_c = 0; hi_c = 0;
        end
        if (tick_i) lo_c++;
      end else if (tick_i) hi_c++;
    end
    if (done_o) begin
      tail_lo       = lo_c;
      car_at_done   = carrier_o;
      busy_at_done  = busy_o;
      stamp_at_done = stamp_o;
    end
    prev_car  = carrier_o;
    prev_busy = busy_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [31:0] d, input int n, input int div, input bit intr);
    int en, cyc, bad_bits;
    logic [7:0] seed;
    tick_div = div;
    en = (n > 32) ? 32 : n;
    @(negedge clk);
    seed = lfsr;
    data_i = d; nbits_i = 6'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o) begin
      @(negedge clk);
      cyc++;
      if (intr && cyc == 200) begin
        start_i = 1'b1; data_i = ~d; nbits_i = 6'd3;
      end else start_i = 1'b0;
    end
    @(negedge clk);
    #1;
    // R5: bit count, LSB first
    check(nb == en, "R5 bit count", nb, en);
    bad_bits = 0;
    for (int i = 0; i < en && i < nb; i++) begin
      int v = d[i] ^ ks_at(seed, i);
      // R2: gap length
      check(bit_lo[i] == PT, "R2 gap ticks", bit_lo[i], PT);
      // R3: coded length
      check(bit_len[i] == (v ? T1 : T0), "R3 bit ticks", bit_len[i], v ? T1 : T0);
      if (bit_lo[i] != PT || bit_len[i] != (v ? T1 : T0)) bad_bits++;
    end
    // R4: one step per bit
    check(steps == en, "R4 step count", steps, en);
    // R6: trailing gap and done clock
    check(tail_lo == PT, "R6 tail ticks", tail_lo, PT);
    check(car_at_done && !busy_at_done, "R6 done state", {car_at_done, busy_at_done}, 2);
    // R7: timestamp cleared at done and counting ticks after
    check(stamp_at_done == 0, "R7 stamp at done", stamp_at_done, 0);
    check(int'(stamp_o) == exp_stamp, "R7 stamp count", stamp_o, exp_stamp);
    if (div != 1) check(bad_bits == 0, "R10 slow ticks", bad_bits, 0);
    if (intr) begin
      repeat (5) @(negedge clk);
      #1;
      // R8: no second frame, original data sent
      check(!busy_o && bad_bits == 0 && nb == en, "R8 start ignored", busy_o, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++; ntot++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(carrier_o == 1'b1, "R1 carrier", carrier_o, 1);
    check(!busy_o && !done_o && !ks_step_o, "R1 flags", {busy_o, done_o, ks_step_o}, 0);
    check(stamp_o == 0, "R1 stamp", stamp_o, 0);
    tick_en = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(carrier_o == 1'b1 && !busy_o, "R1 idle carrier", carrier_o, 1);
    // R9: kill forces carrier off
    @(negedge clk);
    kill_i = 1'b1;
    #1;
    check(carrier_o == 1'b0, "R9 kill low", carrier_o, 0);
    repeat (5) @(negedge clk);
    #1;
    check(!busy_o, "R9 busy unaffected", busy_o, 0);
    @(negedge clk);
    kill_i = 1'b0;
    #1;
    check(carrier_o == 1'b1, "R9 release", carrier_o, 1);

    send_frame(32'h0, 0, 1, 1'b0);              // R5 zero count
    send_frame(32'hFFFF_FFFF, 32, 1, 1'b0);
    send_frame(32'h0000_0000, 32, 1, 1'b0);
    for (int n = 1; n <= 32; n++)
      send_frame(32'hA5C3_0F96 ^ (32'(n) * 32'h0101_0101), n, 1, 1'b0);
    send_frame(32'h1357_9BDF, 40, 1, 1'b0);     // R5 clamp
    send_frame(32'h0000_0B6D, 12, 3, 1'b0);     // R10
    send_frame(32'h0000_02C5, 10, 1, 1'b1);     // R8

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule